// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit host bus and a plug-in cartridge carrying 512 KB of ROM and 512 KB of RAM. The host sees a 32 KB window made of two 16 KB halves. Each half has its own 5-bit page number and its own 2-bit mapping mode. The mode chooses one of four options: nothing, read/write RAM, write-protected RAM, or ROM. For every host access inside the window, the block drives the upper memory address lines from the page of the half being addressed. The 14 offset bits pass straight through. The block also drives active-low ROM and RAM chip enables, a shared output enable and the RAM write enable.

Software programs the two halves through a pair of byte registers placed just below 0xC000, outside the window. The register at 0xBFFE controls the lower half and the one at 0xBFFF controls the upper half. A register write is latched while the host write strobe is low and takes effect when the strobe rises. Reading either register returns its current contents, so software can save and later restore a mapping. After reset, both halves map ROM page 0, so a plain single-bank ROM image runs unchanged.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, both configuration registers read back 0x60, which is ROM mode with page 0.
- R2: Register byte format: bits 4:0 hold the page and bits 6:5 hold the mode (0 none, 1 RAM read/write, 2 RAM write-protected, 3 ROM). Bit 7 is ignored on write and reads as 0. Address 0xBFFE selects the lower half and 0xBFFF the upper half. Writes to any other address leave both registers unchanged.
- R3: A register write changes the register only on the clock edge that first samples the write strobe high after it was low. Before that edge, readback still shows the old value.
- R4: Inside the window (host address bit 15 = 0), bit 14 selects the half. `mem_page` carries that half's page and `mem_offset` equals host address bits 13:0. Outside the window, `mem_page` is 0.
- R5: In mode 0, no chip enable, output enable or write enable is asserted for that half.
- R6: In mode 1, RAM chip enable is asserted on a read or a write. Output enable is asserted on a read. Write enable is asserted on a write.
- R7: In mode 2, reads behave as in mode 1. On a write, RAM chip enable is asserted but write enable stays high.
- R8: In mode 3, ROM chip enable and output enable are asserted on a read. A write asserts no enable at all.
- R9: A read of 0xBFFE or 0xBFFF raises `bus_rdrive` and puts the register value on `bus_rdata`. A read of any other address leaves `bus_rdrive` low and `bus_rdata` at 0.
- R10: Accesses outside the window assert no memory enable.
- R11: The two halves are independent: any mode and page pair in one half works with any pair in the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, active low |
| bus_rdata | output | 8 | Register readback data |
| bus_rdrive | output | 1 | High while the block drives readback data |
| mem_page | output | 5 | Upper memory address (page number) |
| mem_offset | output | 14 | Lower memory address, passed through |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |

## Verification
The hardest case to reach is the single clock edge on which a register write commits. At that edge the strobe has just risen, and at the same moment the host may already be reading the register back. The bench holds the write strobe low for a cycle, then releases it and lowers the read strobe together between clock edges. It expects the old value before the commit edge and the new value after it. A sweep over all sixteen mode pairings, with varied pages, offsets at both ends of each half, and reads and writes, covers the mode gating that the halves share.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

    localparam int ADDR_W     = 16;
    localparam int DATA_W     = 8;
    localparam int PAGE_W     = 14;
    localparam int BANK_W     = 5;
    localparam int NUM_HALVES = 2;
    localparam int HALF_SEL_W = $clog2(NUM_HALVES);
    localparam int TAG_W      = ADDR_W - PAGE_W - HALF_SEL_W;

    typedef enum logic [1:0] {
        MAP_NONE   = 2'd0,
        MAP_RAM_RW = 2'd1,
        MAP_RAM_RO = 2'd2,
        MAP_ROM    = 2'd3
    } map_mode_e;

    typedef struct packed {
        map_mode_e          mode;
        logic [BANK_W-1:0]  bank;
    } half_cfg_t;

    localparam int CFG_W = $bits(half_cfg_t);

    localparam half_cfg_t CFG_RESET = '{mode: MAP_ROM, bank: '0};

    typedef struct packed {
        logic                       hit;
        logic [HALF_SEL_W-1:0]      half;
        logic [PAGE_W-1:0]          offset;
    } win_dec_t;

    typedef struct packed {
        logic rom_ce;
        logic ram_ce;
        logic oe;
        logic we;
    } mem_ctl_t;

    function automatic logic [DATA_W-1:0] pack_cfg(input half_cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[CFG_W-1:0] = c;
        return r;
    endfunction

    function automatic mem_ctl_t gate_mode(input map_mode_e m, input logic rd, input logic wr);
        mem_ctl_t g;
        g = '0;
        case (m)
            MAP_RAM_RW: begin
                g.ram_ce = rd | wr;
                g.oe     = rd;
                g.we     = wr;
            end
            MAP_RAM_RO: begin
                g.ram_ce = rd | wr;
                g.oe     = rd;
            end
            MAP_ROM: begin
                g.rom_ce = rd;
                g.oe     = rd;
            end
            default: g = '0;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/cart_strobe_capture.sv
module cart_strobe_capture
    import cart_bank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_BASE = 16'hBFFE
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wr_n,
    output logic                  commit,
    output logic [HALF_SEL_W-1:0] commit_half,
    output half_cfg_t             commit_cfg
);

    logic                  wr_n_q;
    logic                  pend_hit;
    logic [HALF_SEL_W-1:0] pend_half;
    half_cfg_t             pend_cfg;
    logic                  reg_hit;
    logic [DATA_W-CFG_W-1:0] unused_wdata_hi;

    assign reg_hit = (bus_addr[ADDR_W-1:HALF_SEL_W] == REG_BASE[ADDR_W-1:HALF_SEL_W]);
    assign unused_wdata_hi = bus_wdata[DATA_W-1:CFG_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_n_q    <= 1'b1;
            pend_hit  <= 1'b0;
            pend_half <= '0;
            pend_cfg  <= CFG_RESET;
        end else begin
            wr_n_q <= bus_wr_n;
            if (!bus_wr_n) begin
                pend_hit  <= reg_hit;
                pend_half <= bus_addr[HALF_SEL_W-1:0];
                pend_cfg  <= half_cfg_t'(bus_wdata[CFG_W-1:0]);
            end
        end
    end

    assign commit      = bus_wr_n && !wr_n_q && pend_hit;
    assign commit_half = pend_half;
    assign commit_cfg  = pend_cfg;

endmodule

// File: rtl/cart_bank_regs.sv
module cart_bank_regs
    import cart_bank_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             commit,
    input  logic [HALF_SEL_W-1:0]            commit_half,
    input  half_cfg_t                        commit_cfg,
    output half_cfg_t [NUM_HALVES-1:0]       cfg_q
);

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg_q[h] <= CFG_RESET;
            end else if (commit && (commit_half == HALF_SEL_W'(h))) begin
                cfg_q[h] <= commit_cfg;
            end
        end
    end

endmodule

// File: rtl/cart_access_decode.sv
module cart_access_decode
    import cart_bank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_BASE = 16'hBFFE,
    parameter logic [TAG_W-1:0]  WIN_TAG  = '0
) (
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic                       bus_rd_n,
    input  logic                       bus_wr_n,
    input  half_cfg_t [NUM_HALVES-1:0] cfg_q,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rdrive,
    output logic [BANK_W-1:0]          mem_page,
    output logic [PAGE_W-1:0]          mem_offset,
    output logic                       rom_ce_n,
    output logic                       ram_ce_n,
    output logic                       mem_oe_n,
    output logic                       mem_we_n
);

    win_dec_t  dec;
    half_cfg_t sel_cfg;
    mem_ctl_t  ctl;
    logic      reg_hit;

    always_comb begin
        dec.hit    = (bus_addr[ADDR_W-1:PAGE_W+HALF_SEL_W] == WIN_TAG);
        dec.half   = bus_addr[PAGE_W+HALF_SEL_W-1:PAGE_W];
        dec.offset = bus_addr[PAGE_W-1:0];
    end

    assign sel_cfg = cfg_q[dec.half];

    always_comb begin
        if (dec.hit) begin
            ctl = gate_mode(sel_cfg.mode, !bus_rd_n, !bus_wr_n);
        end else begin
            ctl = '0;
        end
    end

    assign mem_page   = dec.hit ? sel_cfg.bank : '0;
    assign mem_offset = dec.offset;
    assign rom_ce_n   = !ctl.rom_ce;
    assign ram_ce_n   = !ctl.ram_ce;
    assign mem_oe_n   = !ctl.oe;
    assign mem_we_n   = !ctl.we;

    assign reg_hit = (bus_addr[ADDR_W-1:HALF_SEL_W] == REG_BASE[ADDR_W-1:HALF_SEL_W]);

    always_comb begin
        bus_rdrive = reg_hit && !bus_rd_n;
        bus_rdata  = bus_rdrive ? pack_cfg(cfg_q[bus_addr[HALF_SEL_W-1:0]]) : '0;
    end

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cart_bank_pkg::*;
#(
    parameter logic [ADDR_W-1:0] REG_BASE = 16'hBFFE,
    parameter logic [TAG_W-1:0]  WIN_TAG  = '0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_rd_n,
    input  logic                bus_wr_n,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rdrive,
    output logic [BANK_W-1:0]   mem_page,
    output logic [PAGE_W-1:0]   mem_offset,
    output logic                rom_ce_n,
    output logic                ram_ce_n,
    output logic                mem_oe_n,
    output logic                mem_we_n
);

    logic                       commit;
    logic [HALF_SEL_W-1:0]      commit_half;
    half_cfg_t                  commit_cfg;
    half_cfg_t [NUM_HALVES-1:0] cfg_q;

    cart_strobe_capture #(.REG_BASE(REG_BASE)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr_n    (bus_wr_n),
        .commit      (commit),
        .commit_half (commit_half),
        .commit_cfg  (commit_cfg)
    );

    cart_bank_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_half (commit_half),
        .commit_cfg  (commit_cfg),
        .cfg_q       (cfg_q)
    );

    cart_access_decode #(.REG_BASE(REG_BASE), .WIN_TAG(WIN_TAG)) u_decode (
        .bus_addr   (bus_addr),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .cfg_q      (cfg_q),
        .bus_rdata  (bus_rdata),
        .bus_rdrive (bus_rdrive),
        .mem_page   (mem_page),
        .mem_offset (mem_offset),
        .rom_ce_n   (rom_ce_n),
        .ram_ce_n   (ram_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n)
    );

endmodule

// File: rtl/cart_bank_ctrl_chk.sv
module cart_bank_ctrl_chk
    import cart_bank_pkg::*;
(
    input logic                       clk,
    input logic                       rst,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic                       bus_rd_n,
    input logic                       bus_wr_n,
    input logic                       bus_rdrive,
    input logic                       rom_ce_n,
    input logic                       ram_ce_n,
    input logic                       mem_oe_n,
    input logic                       mem_we_n,
    input half_cfg_t [NUM_HALVES-1:0] cfg_q
);

    AST_CE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!rom_ce_n && !ram_ce_n)); // R10

    AST_WE_NEEDS_RAM: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!ram_ce_n && !bus_wr_n)); // R6

    AST_ROM_READ_ONLY: assert property (@(posedge clk) disable iff (rst)
        !rom_ce_n |-> (!bus_rd_n && !mem_oe_n)); // R8

    AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_addr[ADDR_W-1] |-> (rom_ce_n && ram_ce_n && mem_oe_n && mem_we_n)); // R10

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr_n && !$past(bus_wr_n)) |=> $stable(cfg_q)); // R3

    AST_READBACK_ON_READ: assert property (@(posedge clk) disable iff (rst)
        bus_rdrive |-> !bus_rd_n); // R9

endmodule

bind cart_bank_ctrl cart_bank_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_rd_n   (bus_rd_n),
    .bus_wr_n   (bus_wr_n),
    .bus_rdrive (bus_rdrive),
    .rom_ce_n   (rom_ce_n),
    .ram_ce_n   (ram_ce_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .cfg_q      (cfg_q)
);

// File: tb/cart_bank_ctrl_tb.sv
module cart_bank_ctrl_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_rd_n = 1'b1;
    logic        bus_wr_n = 1'b1;
    logic [7:0]  bus_rdata;
    logic        bus_rdrive;
    logic [4:0]  mem_page;
    logic [13:0] mem_offset;
    logic        rom_ce_n, ram_ce_n, mem_oe_n, mem_we_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [1:0] m_mode [2];
    logic [4:0] m_bank [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_bank_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_rdata(bus_rdata),
        .bus_rdrive(bus_rdrive), .mem_page(mem_page), .mem_offset(mem_offset),
        .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read_reg(input int half, input string req, input logic [7:0] exp);
        @(negedge clk);
        bus_addr = 16'hBFFE + 16'(half);
        bus_rd_n = 1'b0;
        #1;
        check(req, {23'd0, bus_rdrive, bus_rdata}, {23'd0, 1'b1, exp});
        @(negedge clk);
        bus_rd_n = 1'b1;
    endtask

    task automatic write_reg(input logic [15:0] addr, input logic [7:0] val);
        @(negedge clk);
        bus_addr  = addr;
        bus_wdata = val;
        bus_wr_n  = 1'b0;
        @(negedge clk);
        bus_wr_n  = 1'b1;
        @(negedge clk);
        if (addr == 16'hBFFE || addr == 16'hBFFF) begin
            m_mode[addr[0]] = val[6:5];
            m_bank[addr[0]] = val[4:0];
        end
    endtask

    function automatic logic [23:0] expect_acc(input logic [15:0] a, input logic rd, input logic wr);
        logic       inwin;
        logic [1:0] md;
        logic [4:0] pg;
        logic rce, mce, oe, we;
        inwin = (a[15] == 1'b0);
        md  = m_mode[a[14]];
        pg  = inwin ? m_bank[a[14]] : 5'd0;
        rce = inwin && md == 2'd3 && rd;
        mce = inwin && (md == 2'd1 || md == 2'd2) && (rd || wr);
        oe  = inwin && md != 2'd0 && rd;
        we  = inwin && md == 2'd1 && wr;
        return {1'b0, pg, a[13:0], !rce, !mce, !oe, !we};
    endfunction

    task automatic access(input logic [15:0] a, input logic rd, input logic wr, input string req);
        @(negedge clk);
        bus_addr = a;
        bus_rd_n = !rd;
        bus_wr_n = !wr;
        #1;
        check(req, {8'd0, 1'b0, mem_page, mem_offset, rom_ce_n, ram_ce_n, mem_oe_n, mem_we_n},
              {8'd0, expect_acc(a, rd, wr)});
        if (!wr) check({req, " no readback"}, {23'd0, bus_rdrive, bus_rdata}, 32'd0);
        @(negedge clk);
        bus_rd_n = 1'b1;
        bus_wr_n = 1'b1;
    endtask

    initial begin
        m_mode[0] = 2'd3; m_mode[1] = 2'd3;
        m_bank[0] = 5'd0; m_bank[1] = 5'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        read_reg(0, "R1 lower reset", 8'h60);
        read_reg(1, "R1 upper reset", 8'h60);
        access(16'h0123, 1'b1, 1'b0, "R1 R8 reset rom read");

        // R11 sweep of every mode pairing
        for (int lm = 0; lm < 4; lm++) begin
            for (int hm = 0; hm < 4; hm++) begin
                logic [4:0] bl, bh;
                bl = 5'((lm * 9 + hm * 5 + 1) % 32);
                bh = ~bl;
                write_reg(16'hBFFE, {1'b1, 2'(lm), bl}); // R2 bit 7 set, ignored
                write_reg(16'hBFFF, {1'b0, 2'(hm), bh});
                read_reg(0, "R2 R9 R11 lower readback", {1'b0, 2'(lm), bl});
                read_reg(1, "R2 R9 R11 upper readback", {1'b0, 2'(hm), bh});
                for (int h = 0; h < 2; h++) begin
                    for (int k = 0; k < 3; k++) begin
                        logic [15:0] a;
                        logic [13:0] off;
                        off = (k == 0) ? 14'h0000 : (k == 1) ? 14'h3FFF : 14'(lm * 1111 + hm * 333);
                        a = {1'b0, 1'(h), off};
                        access(a, 1'b1, 1'b0, "R4 R5 R6 R7 R8 read");
                        access(a, 1'b0, 1'b1, "R4 R5 R6 R7 R8 write");
                        access(a, 1'b0, 1'b0, "R4 idle");
                    end
                end
                // R10 outside the window
                access(16'h8000 + 16'(lm * 4096 + hm * 17), 1'b1, 1'b0, "R10 outside read");
                access(16'hBFFD, 1'b0, 1'b1, "R10 outside write");
            end
        end

        // R2 writes to non-register addresses do not change the registers
        write_reg(16'hBFFE, 8'h2A);
        write_reg(16'hBFFF, 8'h45);
        write_reg(16'hBFFD, 8'h7F);
        write_reg(16'h1000, 8'h00);
        write_reg(16'hC000, 8'h11);
        read_reg(0, "R2 other address ignored lower", 8'h2A);
        read_reg(1, "R2 other address ignored upper", 8'h45);
        access(16'h1000, 1'b0, 1'b1, "R6 rw write after foreign writes");

        // R3 commit only on the sampled strobe rise
        @(negedge clk);
        bus_addr  = 16'hBFFF;
        bus_wdata = 8'h33;
        bus_wr_n  = 1'b0;
        @(negedge clk);
        bus_wr_n  = 1'b1;
        bus_rd_n  = 1'b0;
        #1;
        check("R3 old value before commit edge", {24'd0, bus_rdata}, 32'h45);
        @(negedge clk);
        check("R3 new value after commit edge", {24'd0, bus_rdata}, 32'h33);
        bus_rd_n = 1'b1;
        m_mode[1] = 2'd1; m_bank[1] = 5'd19;
        access(16'h7FFF, 1'b0, 1'b1, "R3 R6 new upper mapping in use");
        read_reg(0, "R3 R11 lower untouched", 8'h2A);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule